// File: doc/BRIEF.md
# Timer Register Byte Interface

This block is the register front end of a 16-bit timer that sits on an 8-bit data bus. It decodes a 4-bit byte address space holding three control bytes, the counter, a capture/top register and three compare registers. It drives the stored values to the timer core and takes the live counter value from the core. The counting, prescaling and interrupt logic all live in the core, not here.

A single temporary byte makes 16-bit counter and capture accesses atomic. A read of a low byte returns the low byte and, in the same access, saves the matching high byte into the temporary byte. A read of the high byte then returns that saved copy. A write to a high byte only fills the temporary byte. The later low-byte write commits both bytes together. The counter and the capture register share this one temporary byte, so software must not interleave their accesses. The capture register can only be written while the timer mode equals 12. The 4-bit mode is assembled from two fields that sit in different control bytes.

A counter commit is handed to the core as a one-cycle load strobe carrying the full 16-bit value. The core also uses that strobe to block compare matching on its next tick.

Top module: `t16_regif`

## Requirements
- R1: Control bytes A, B and C sit at addresses 0x0, 0x1 and 0x2. Each is written and read back as a full byte and appears on its own output.
- R2: `mode_o` equals {control B bits 4:3, control A bits 1:0}. Control B supplies mode bits 3:2 and control A supplies mode bits 1:0.
- R3: A read of 0x4 returns the live counter low byte and copies the live counter high byte into the temporary byte. A read of 0x5 returns the temporary byte, not the live high byte.
- R4: A write to 0x5 only loads the temporary byte and raises no load strobe. A write to 0x4 raises `cnt_load_o` for exactly one cycle, in the cycle after the access, with `cnt_load_val_o` = {temporary byte, written byte}.
- R5: Writes to 0x6 and 0x7 change neither the capture register nor the temporary byte unless the mode equals 12.
- R6: The capture register shares the temporary byte with the counter. A read of 0x6 copies the capture high byte into the temporary byte. In mode 12, a write to 0x7 loads the temporary byte and a write to 0x6 loads the capture register with {temporary byte, written byte}.
- R7: The compare registers are accessed directly, with no temporary buffering. Compare A uses 0x8 (low) and 0x9 (high), compare B uses 0xA/0xB, and compare C uses 0xC/0xD. `cmp_o` packs them as {C, B, A}.
- R8: Addresses 0x3, 0xE and 0xF read as zero and ignore writes.
- R9: Read data appears on `bus_rdata_o` in the cycle after the read access. In any cycle after a non-read, `bus_rdata_o` is zero.
- R10: Reset clears every register, the temporary byte, the load strobe and the read data to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_sel_i | input | 1 | Byte access valid this cycle |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 4 | Byte address |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, one cycle after the access |
| cnt_i | input | 16 | Live counter value from the timer core |
| cnt_load_o | output | 1 | One-cycle counter load strobe |
| cnt_load_val_o | output | 16 | Value for the counter load |
| ctrl_a_o | output | 8 | Control byte A |
| ctrl_b_o | output | 8 | Control byte B |
| ctrl_c_o | output | 8 | Control byte C |
| mode_o | output | 4 | Assembled timer mode |
| cap_o | output | 16 | Capture/top register |
| cmp_o | output | 48 | Compare registers {C, B, A} |

## Verification
Every output is registered. Read data, the load strobe with its value, and every register output are due on the first clock edge after the access. The driver applies each access on a falling edge and pushes the expected read byte into a queue. A monitor pops one entry on the following falling edge when a read was accepted on the rising edge in between. Register and strobe outputs are sampled on the falling edge right after the access and again one idle cycle later, which catches both a missing strobe and a strobe that lasts too long.

// File: rtl/t16_regif_pkg.sv
package t16_regif_pkg;
  localparam int unsigned ADDR_W = 4;
  localparam logic [ADDR_W-1:0] A_CTRL_A = 4'h0;
  localparam logic [ADDR_W-1:0] A_CTRL_B = 4'h1;
  localparam logic [ADDR_W-1:0] A_CTRL_C = 4'h2;
  localparam logic [ADDR_W-1:0] A_CNT_LO = 4'h4;
  localparam logic [ADDR_W-1:0] A_CNT_HI = 4'h5;
  localparam logic [ADDR_W-1:0] A_CAP_LO = 4'h6;
  localparam logic [ADDR_W-1:0] A_CAP_HI = 4'h7;
  localparam int unsigned       A_CMP_BASE = 8;
  localparam logic [3:0]        MODE_CAP_WR = 4'd12;
endpackage

// File: rtl/t16_addr_dec.sv
module t16_addr_dec #(
  parameter int unsigned AW = 4,
  localparam int unsigned NA = 1 << AW
) (
  input  logic          sel_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  output logic [NA-1:0] wr_o,
  output logic [NA-1:0] rd_o
);
  for (genvar i = 0; i < NA; i++) begin : g_dec
    assign wr_o[i] = sel_i &&  we_i && (addr_i == AW'(i));
    assign rd_o[i] = sel_i && !we_i && (addr_i == AW'(i));
  end
endmodule

// File: rtl/t16_byte_pair.sv
module t16_byte_pair #(
  parameter int unsigned DW = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_lo_i,
  input  logic            wr_hi_i,
  input  logic [DW-1:0]   wdata_i,
  output logic [2*DW-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else begin
      if (wr_lo_i) q_o[DW-1:0]    <= wdata_i;
      if (wr_hi_i) q_o[2*DW-1:DW] <= wdata_i;
    end
  end
endmodule

// File: rtl/t16_rd_mux.sv
module t16_rd_mux
  import t16_regif_pkg::*;
#(
  parameter int unsigned DW   = 8,
  parameter int unsigned NCMP = 3,
  localparam int unsigned WW  = 2 * DW
) (
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DW-1:0]      ctrl_a_i,
  input  logic [DW-1:0]      ctrl_b_i,
  input  logic [DW-1:0]      ctrl_c_i,
  input  logic [DW-1:0]      cnt_lo_i,
  input  logic [DW-1:0]      cap_lo_i,
  input  logic [DW-1:0]      temp_i,
  input  logic [NCMP*WW-1:0] cmp_i,
  output logic [DW-1:0]      rdata_o
);
  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_CTRL_A: rdata_o = ctrl_a_i;
      A_CTRL_B: rdata_o = ctrl_b_i;
      A_CTRL_C: rdata_o = ctrl_c_i;
      A_CNT_LO: rdata_o = cnt_lo_i;
      A_CNT_HI: rdata_o = temp_i;
      A_CAP_LO: rdata_o = cap_lo_i;
      A_CAP_HI: rdata_o = temp_i;
      default: ;
    endcase
    for (int k = 0; k < NCMP; k++) begin
      if (addr_i == ADDR_W'(A_CMP_BASE + 2*k))     rdata_o = cmp_i[k*WW +: DW];
      if (addr_i == ADDR_W'(A_CMP_BASE + 2*k + 1)) rdata_o = cmp_i[k*WW+DW +: DW];
    end
  end
endmodule

// File: rtl/t16_regif.sv
module t16_regif
  import t16_regif_pkg::*;
#(
  parameter int unsigned DW   = 8,
  parameter int unsigned NCMP = 3,
  localparam int unsigned WW  = 2 * DW,
  localparam int unsigned NA  = 1 << ADDR_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               bus_sel_i,
  input  logic               bus_we_i,
  input  logic [ADDR_W-1:0]  bus_addr_i,
  input  logic [DW-1:0]      bus_wdata_i,
  output logic [DW-1:0]      bus_rdata_o,
  input  logic [WW-1:0]      cnt_i,
  output logic               cnt_load_o,
  output logic [WW-1:0]      cnt_load_val_o,
  output logic [DW-1:0]      ctrl_a_o,
  output logic [DW-1:0]      ctrl_b_o,
  output logic [DW-1:0]      ctrl_c_o,
  output logic [3:0]         mode_o,
  output logic [WW-1:0]      cap_o,
  output logic [NCMP*WW-1:0] cmp_o
);
  logic [NA-1:0] wr, rd;
  logic [DW-1:0] temp_q, rd_byte;
  logic          cap_wr_ok;

  t16_addr_dec #(.AW(ADDR_W)) u_dec (
    .sel_i(bus_sel_i), .we_i(bus_we_i), .addr_i(bus_addr_i),
    .wr_o(wr), .rd_o(rd)
  );

  assign mode_o    = {ctrl_b_o[4:3], ctrl_a_o[1:0]};
  assign cap_wr_ok = (mode_o == MODE_CAP_WR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_a_o <= '0;
      ctrl_b_o <= '0;
      ctrl_c_o <= '0;
    end else begin
      if (wr[A_CTRL_A]) ctrl_a_o <= bus_wdata_i;
      if (wr[A_CTRL_B]) ctrl_b_o <= bus_wdata_i;
      if (wr[A_CTRL_C]) ctrl_c_o <= bus_wdata_i;
    end
  end

  // Shared high-byte latch for counter and capture
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) temp_q <= '0;
    else if (rd[A_CNT_LO])               temp_q <= cnt_i[WW-1:DW];
    else if (wr[A_CNT_HI])               temp_q <= bus_wdata_i;
    else if (rd[A_CAP_LO])               temp_q <= cap_o[WW-1:DW];
    else if (wr[A_CAP_HI] && cap_wr_ok)  temp_q <= bus_wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cap_o <= '0;
    else if (wr[A_CAP_LO] && cap_wr_ok) cap_o <= {temp_q, bus_wdata_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_load_o     <= 1'b0;
      cnt_load_val_o <= '0;
    end else begin
      cnt_load_o <= wr[A_CNT_LO];
      if (wr[A_CNT_LO]) cnt_load_val_o <= {temp_q, bus_wdata_i};
    end
  end

  for (genvar k = 0; k < NCMP; k++) begin : g_cmp
    t16_byte_pair #(.DW(DW)) u_cmp (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .wr_lo_i(wr[A_CMP_BASE + 2*k]),
      .wr_hi_i(wr[A_CMP_BASE + 2*k + 1]),
      .wdata_i(bus_wdata_i),
      .q_o(cmp_o[k*WW +: WW])
    );
  end

  t16_rd_mux #(.DW(DW), .NCMP(NCMP)) u_mux (
    .addr_i(bus_addr_i), .ctrl_a_i(ctrl_a_o), .ctrl_b_i(ctrl_b_o),
    .ctrl_c_i(ctrl_c_o), .cnt_lo_i(cnt_i[DW-1:0]), .cap_lo_i(cap_o[DW-1:0]),
    .temp_i(temp_q), .cmp_i(cmp_o), .rdata_o(rd_byte)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) bus_rdata_o <= '0;
    else bus_rdata_o <= (bus_sel_i && !bus_we_i) ? rd_byte : '0;
  end
endmodule

// File: rtl/t16_regif_chk.sv
module t16_regif_chk
  import t16_regif_pkg::*;
#(
  parameter int unsigned DW   = 8,
  parameter int unsigned NCMP = 3,
  localparam int unsigned WW  = 2 * DW
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               bus_sel_i,
  input logic               bus_we_i,
  input logic [ADDR_W-1:0]  bus_addr_i,
  input logic [DW-1:0]      bus_wdata_i,
  input logic [DW-1:0]      bus_rdata_o,
  input logic [WW-1:0]      cnt_i,
  input logic               cnt_load_o,
  input logic [3:0]         mode_o,
  input logic [WW-1:0]      cap_o,
  input logic [NCMP*WW-1:0] cmp_o
);
  logic wr_acc, rd_acc;
  assign wr_acc = bus_sel_i && bus_we_i;
  assign rd_acc = bus_sel_i && !bus_we_i;

  a_r4_load_on_lo_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_acc && bus_addr_i == A_CNT_LO) |=> cnt_load_o);
  a_r4_no_stray_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_acc && bus_addr_i == A_CNT_LO) |=> !cnt_load_o);
  a_r3_cnt_lo_live: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_acc && bus_addr_i == A_CNT_LO) |=> bus_rdata_o == $past(cnt_i[DW-1:0]));
  a_r5_cap_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_acc && (bus_addr_i == A_CAP_LO || bus_addr_i == A_CAP_HI) && mode_o != MODE_CAP_WR)
    |=> $stable(cap_o));
  a_r7_cmp_a_lo: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_acc && bus_addr_i == ADDR_W'(A_CMP_BASE)) |=> cmp_o[DW-1:0] == $past(bus_wdata_i));
  a_r8_hole_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_acc && (bus_addr_i == 4'h3 || bus_addr_i >= ADDR_W'(A_CMP_BASE + 2*NCMP)))
    |=> bus_rdata_o == '0);
  a_r9_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_acc |=> bus_rdata_o == '0);
endmodule

bind t16_regif t16_regif_chk #(.DW(DW), .NCMP(NCMP)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .bus_sel_i(bus_sel_i), .bus_we_i(bus_we_i),
  .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o),
  .cnt_i(cnt_i), .cnt_load_o(cnt_load_o), .mode_o(mode_o), .cap_o(cap_o),
  .cmp_o(cmp_o)
);

// File: tb/tb_t16_regif.sv
`timescale 1ns/1ps
module tb_t16_regif;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sel = 1'b0, we = 1'b0;
  logic [3:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [15:0] cnt = '0;
  logic        load;
  logic [15:0] load_val, cap;
  logic [7:0]  ca, cb, cc;
  logic [3:0]  mode;
  logic [47:0] cmp;

  int n_chk = 0, n_bad = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic       rd_seen = 1'b0;

  always #2.5 clk = ~clk;

  t16_regif dut (
    .clk_i(clk), .rst_ni(rst_ni), .bus_sel_i(sel), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .cnt_i(cnt), .cnt_load_o(load), .cnt_load_val_o(load_val),
    .ctrl_a_o(ca), .ctrl_b_o(cb), .ctrl_c_o(cc), .mode_o(mode),
    .cap_o(cap), .cmp_o(cmp)
  );

  task automatic check(string req, logic [47:0] act, logic [47:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Driver: one access per cycle, returns on the falling edge after it
  task automatic wr(logic [3:0] a, logic [7:0] d);
    sel = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    sel = 1'b0; we = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, logic [7:0] e, string req);
    sel = 1'b1; we = 1'b0; addr = a;
    exp_q.push_back(e); tag_q.push_back(req);
    @(negedge clk);
    sel = 1'b0;
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  // Monitor
  always @(posedge clk) rd_seen <= rst_ni && sel && !we;
  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_bad++;
        $display("FAIL R9: unexpected read data %h expected none", rdata);
      end else begin
        string t;
        logic [7:0] e;
        e = exp_q.pop_front(); t = tag_q.pop_front();
        check(t, {40'h0, rdata}, {40'h0, e});
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R10 reset state
    check("R10 ctrl", {ca, cb, cc}, 0);
    check("R10 mode", mode, 0);
    check("R10 cap", cap, 0);
    check("R10 cmp", cmp, 0);
    check("R10 load", {load, load_val}, 0);
    check("R10 rdata", rdata, 0);
    rd(4'h5, 8'h00, "R10 temp");

    // R1 control bytes
    wr(4'h0, 8'hA1); wr(4'h1, 8'h42); wr(4'h2, 8'h5C);
    check("R1 outputs", {ca, cb, cc}, 24'hA1425C);
    rd(4'h0, 8'hA1, "R1 ctrl A"); rd(4'h1, 8'h42, "R1 ctrl B"); rd(4'h2, 8'h5C, "R1 ctrl C");

    // R2 mode assembly
    wr(4'h0, 8'h02); wr(4'h1, 8'h08);
    check("R2 mode 6", mode, 4'd6);

    // R3 snapshot
    cnt = 16'hA55A;
    rd(4'h4, 8'h5A, "R3 live lo");
    cnt = 16'h1234;
    rd(4'h5, 8'hA5, "R3 temp hi");
    rd(4'h4, 8'h34, "R3 live lo 2"); rd(4'h5, 8'h12, "R3 temp hi 2");

    // R4 counter write
    wr(4'h5, 8'h3C);
    check("R4 no load on hi", load, 0);
    wr(4'h4, 8'h7E);
    check("R4 load", {load, load_val}, {1'b1, 16'h3C7E});
    idle();
    check("R4 one cycle", load, 0);

    // R5 capture locked outside mode 12
    wr(4'h7, 8'h11); wr(4'h6, 8'h22);
    check("R5 cap held", cap, 0);
    wr(4'h4, 8'h01);
    check("R5 temp untouched", load_val, 16'h3C01);
    rd(4'h6, 8'h00, "R5 cap lo");

    // R6 capture in mode 12 and shared temp
    wr(4'h0, 8'h00); wr(4'h1, 8'h18);
    check("R2 mode 12", mode, 4'd12);
    wr(4'h7, 8'hBE); wr(4'h6, 8'hEF);
    check("R6 cap commit", cap, 16'hBEEF);
    rd(4'h6, 8'hEF, "R6 cap lo"); rd(4'h7, 8'hBE, "R6 cap hi");
    wr(4'h4, 8'h00);
    check("R6 shared temp into cnt", load_val, 16'hBE00);
    wr(4'h5, 8'h77); wr(4'h6, 8'h01);
    check("R6 shared temp into cap", cap, 16'h7701);

    // R7 compare registers
    wr(4'h8, 8'h11); wr(4'h9, 8'h22); wr(4'hA, 8'h33);
    wr(4'hB, 8'h44); wr(4'hC, 8'h55); wr(4'hD, 8'h66);
    check("R7 cmp", cmp, 48'h665544332211);
    rd(4'h9, 8'h22, "R7 cmp A hi"); rd(4'hC, 8'h55, "R7 cmp C lo");

    // R8 holes
    wr(4'h3, 8'hFF); wr(4'hE, 8'hFF); wr(4'hF, 8'hFF);
    check("R8 ctrl kept", {ca, cb, cc}, 24'h00185C);
    check("R8 cmp kept", cmp, 48'h665544332211);
    check("R8 cap kept", cap, 16'h7701);
    check("R8 no load", load, 0);
    rd(4'h3, 8'h00, "R8 0x3"); rd(4'hE, 8'h00, "R8 0xE"); rd(4'hF, 8'h00, "R8 0xF");

    // R9 idle read data
    idle();
    check("R9 idle zero", rdata, 0);
    idle();
    check("R9 queue drained", exp_q.size(), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule